// File: doc/BRIEF.md
# Configurable LUT/Flip-Flop Logic Tile

This block is one programmable logic tile of a fabric. It holds eight slices. Each slice has a 4-input lookup table (LUT) and one rising-edge flip-flop. Each LUT input picks its wire from the tile's four directional input buses (north, east, south, west, ten wires each) or from the tile's own eight slice outputs. Each flip-flop clock picks its wire from the forty bus wires only. A 2:1 selector feeds the flip-flop: it takes either the LUT result or the LUT's top input. A second 2:1 selector chooses whether the slice drives its LUT result or its flip-flop state onto the slice output bus. That bus goes to the neighbouring switch box.

All choices live in a configuration chain. The chain is loaded one bit per clock while the configuration enable is high. While the tile is being loaded, and in reset, the slice output bus is forced to zero. The bus is also forced to zero where it feeds back inside the tile, so a half-loaded chain cannot form a live logic loop. The outputs become live on the first clock edge at which the enable is low.

Top module: `logic_tile`

## Requirements
- R1: After reset, every slice output reads 0 and every flip-flop holds 0 until its selected clock rises.
- R2: While cfg_en_i is high, each clk_i rising edge shifts cfg_bit_i into the top of a 384-bit chain, and every bit moves one place towards bit 0. The first bit sent therefore ends at bit 0. Slice s owns chain bits [48s+47:48s]. Within those bits: [15:0] truth table, [21:16] input-0 select, [27:22] input-1 select, [33:28] input-2 select, [39:34] input-3 select, [45:40] clock select, [46] flip-flop source (1 = LUT input 3, 0 = LUT result), [47] output source (1 = flip-flop, 0 = LUT result). While cfg_en_i is low the chain holds.
- R3: slice_out_o reads all zeros while cfg_en_i is high. It becomes live on the first clk_i rising edge that samples cfg_en_i low.
- R4: The LUT result equals truth[{i3,i2,i1,i0}]: input 3 chooses a byte, and input 0 makes the last choice.
- R5: A 6-bit input select code c picks bus_n_i[c] for 0–9, bus_e_i[c-10] for 10–19, bus_s_i[c-20] for 20–29, bus_w_i[c-30] for 30–39, and slice output c-40 for 40–47. Codes 48–63 give logic 0.
- R6: The flip-flop captures on the rising edge of its selected clock. The clock select uses the codes 0–39 as in R5, and codes 40–63 give a constant-0 clock that never captures.
- R7: With the flip-flop source bit at 1, the flip-flop registers LUT input 3. With it at 0, the flip-flop registers the LUT result.
- R8: With the output source bit at 1, the slice drives its flip-flop state. With it at 0, the slice drives its LUT result.
- R9: A truth table of 0xFFFF drives 1 and a truth table of 0x0000 drives 0, for every input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en_i | input | 1 | High while configuration bits are shifted in |
| cfg_bit_i | input | 1 | Serial configuration data |
| bus_n_i | input | 10 | North input bus |
| bus_e_i | input | 10 | East input bus |
| bus_s_i | input | 10 | South input bus |
| bus_w_i | input | 10 | West input bus |
| slice_out_o | output | 8 | Slice output bus, bit s from slice s |

## Verification
On every cycle, the assertions check three things. The output bus is quiet during loading and in reset. Each shift enters the serial bit at the top of the chain and moves every other bit down one place. The chain stays still whenever loading is off. Only the bench scenarios can show the rest, because it depends on a loaded pattern and on bus stimulus: the LUT tree order, the mapping of select codes to wires, the out-of-range codes, the flip-flop and output source choices, and feedback from one slice into another. The bench loads one fixed image that uses every feature. It then sweeps 128 bus patterns and gives one flip-flop clock pulse per pattern. The full 16-entry sweep of one LUT is part of this sweep.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int LT_SLICES   = 8;
  localparam int LT_LUT_K    = 4;
  localparam int LT_BUS_W    = 10;
  localparam int LT_SEL_W    = 6;
  localparam int LT_TRUTH_W  = 1 << LT_LUT_K;
  localparam int LT_CLK_SRC_N = 4 * LT_BUS_W;
  localparam int LT_SRC_N    = LT_CLK_SRC_N + LT_SLICES;
  localparam int LT_SEL_SPAN = 1 << LT_SEL_W;

  // Packed: first member is the most significant field.
  typedef struct packed {
    logic                                  use_q;
    logic                                  d_from_top;
    logic [LT_SEL_W-1:0]                   clk_sel;
    logic [LT_LUT_K-1:0][LT_SEL_W-1:0]     in_sel;
    logic [LT_TRUTH_W-1:0]                 truth;
  } slice_cfg_t;

  localparam int LT_SLICE_CFG_W = $bits(slice_cfg_t);
  localparam int LT_CFG_W       = LT_SLICES * LT_SLICE_CFG_W;
endpackage

// File: rtl/lt_rst_sync.sv
module lt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_sync_no = pipe_q[STAGES-1];
endmodule

// File: rtl/lt_cfg_chain.sv
module lt_cfg_chain
  import lt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_en_i,
  input  logic                cfg_bit_i,
  output logic [LT_CFG_W-1:0] cfg_o,
  output logic                live_o
);
  logic [LT_CFG_W-1:0] chain_q, chain_d;
  logic                live_q, live_d;

  always_comb begin
    chain_d = chain_q;
    if (cfg_en_i) chain_d = {cfg_bit_i, chain_q[LT_CFG_W-1:1]};
    live_d = ~cfg_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      live_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      live_q  <= live_d;
    end
  end

  assign cfg_o  = chain_q;
  assign live_o = live_q;
endmodule

// File: rtl/lt_slice.sv
module lt_slice
  import lt_pkg::*;
(
  input  logic                    rst_ni,
  input  slice_cfg_t              cfg_i,
  input  logic [LT_SRC_N-1:0]     src_i,
  input  logic [LT_CLK_SRC_N-1:0] clk_src_i,
  output logic                    out_o
);
  localparam int DATA_PAD = LT_SEL_SPAN - LT_SRC_N;
  localparam int CLK_PAD  = LT_SEL_SPAN - LT_CLK_SRC_N;

  logic [LT_SEL_SPAN-1:0] src_pad, clk_pad;
  logic [LT_LUT_K-1:0]    lut_in;
  logic [LT_TRUTH_W-1:0]  stage;
  logic                   lut_f, ff_clk, ff_d, ff_q;

  // Unused select codes land on the zero padding.
  assign src_pad = {{DATA_PAD{1'b0}}, src_i};
  assign clk_pad = {{CLK_PAD{1'b0}}, clk_src_i};

  for (genvar k = 0; k < LT_LUT_K; k++) begin : g_in_sel
    assign lut_in[k] = src_pad[cfg_i.in_sel[k]];
  end

  assign ff_clk = clk_pad[cfg_i.clk_sel];

  // Mux tree: the top input halves the table first, input 0 picks last.
  always_comb begin
    stage = cfg_i.truth;
    for (int lvl = LT_LUT_K - 1; lvl >= 0; lvl--) begin
      for (int j = 0; j < (1 << lvl); j++) begin
        stage[j] = lut_in[lvl] ? stage[j + (1 << lvl)] : stage[j];
      end
    end
    lut_f = stage[0];
  end

  assign ff_d = cfg_i.d_from_top ? lut_in[LT_LUT_K-1] : lut_f;

  always_ff @(posedge ff_clk or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 1'b0;
    else         ff_q <= ff_d;
  end

  assign out_o = cfg_i.use_q ? ff_q : lut_f;
endmodule

// File: rtl/logic_tile.sv
module logic_tile
  import lt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_en_i,
  input  logic                 cfg_bit_i,
  input  logic [LT_BUS_W-1:0]  bus_n_i,
  input  logic [LT_BUS_W-1:0]  bus_e_i,
  input  logic [LT_BUS_W-1:0]  bus_s_i,
  input  logic [LT_BUS_W-1:0]  bus_w_i,
  output logic [LT_SLICES-1:0] slice_out_o
);
  logic                     rst_sync_n;
  logic [LT_CFG_W-1:0]      cfg_q;
  logic                     live;
  logic [LT_SLICES-1:0]     slice_raw;
  logic [LT_CLK_SRC_N-1:0]  bus_all;
  logic [LT_SRC_N-1:0]      src_all;
  slice_cfg_t               scfg [LT_SLICES];

  lt_rst_sync #(.STAGES(2)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  lt_cfg_chain u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .cfg_en_i (cfg_en_i),
    .cfg_bit_i(cfg_bit_i),
    .cfg_o    (cfg_q),
    .live_o   (live)
  );

  // Gated bus also feeds back, so a partial image cannot form a live loop.
  assign slice_out_o = live ? slice_raw : '0;
  assign bus_all     = {bus_w_i, bus_s_i, bus_e_i, bus_n_i};
  assign src_all     = {slice_out_o, bus_all};

  for (genvar s = 0; s < LT_SLICES; s++) begin : g_slice
    assign scfg[s] = slice_cfg_t'(cfg_q[s*LT_SLICE_CFG_W +: LT_SLICE_CFG_W]);
    lt_slice u_slice (
      .rst_ni   (rst_sync_n),
      .cfg_i    (scfg[s]),
      .src_i    (src_all),
      .clk_src_i(bus_all),
      .out_o    (slice_raw[s])
    );
  end
endmodule

// File: rtl/lt_checker.sv
module lt_checker
  import lt_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rst_sync_n,
  input logic                 cfg_en_i,
  input logic                 cfg_bit_i,
  input logic [LT_CFG_W-1:0]  cfg_q,
  input logic [LT_SLICES-1:0] slice_out_o
);
  // R3: bus quiet on the cycle after loading was enabled
  p_quiet_cfg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (slice_out_o == '0));

  // R2: new bit enters at the top
  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cfg_en_i |=> (cfg_q[LT_CFG_W-1] == $past(cfg_bit_i)));

  // R2: other bits move one place towards bit 0
  p_shift_down_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cfg_en_i |=> (cfg_q[LT_CFG_W-2:0] == $past(cfg_q[LT_CFG_W-1:1])));

  // R2: chain holds while loading is off
  p_hold_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !cfg_en_i |=> $stable(cfg_q));

  // R1: bus quiet while reset is applied
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_quiet_reset_r1: assert (slice_out_o == '0);
    end
  end
endmodule

bind logic_tile lt_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_sync_n (rst_sync_n),
  .cfg_en_i   (cfg_en_i),
  .cfg_bit_i  (cfg_bit_i),
  .cfg_q      (cfg_q),
  .slice_out_o(slice_out_o)
);

// File: tb/logic_tile_tb.sv
module logic_tile_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_en_i, cfg_bit_i;
  logic [9:0] bus_n_i, bus_e_i, bus_s_i, bus_w_i;
  logic [7:0] slice_out_o;

  int checks = 0;
  int errors = 0;
  logic [383:0] img;
  logic q0_m, q3_m;

  always #10 clk_i = ~clk_i;

  logic_tile dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
    .bus_n_i(bus_n_i), .bus_e_i(bus_e_i), .bus_s_i(bus_s_i), .bus_w_i(bus_w_i),
    .slice_out_o(slice_out_o)
  );

  function automatic logic [47:0] mk(input logic uq, input logic dtop,
      input logic [5:0] ck, input logic [5:0] i3, input logic [5:0] i2,
      input logic [5:0] i1, input logic [5:0] i0, input logic [15:0] t);
    return {uq, dtop, ck, i3, i2, i1, i0, t};
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic chk_bus(input logic [7:0] exp, input string tag);
    checks++;
    if (slice_out_o !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, slice_out_o, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cfg_en_i = 1'b0; cfg_bit_i = 1'b0;
    bus_n_i = '0; bus_e_i = '0; bus_s_i = '0; bus_w_i = '0;
    q0_m = 1'b0; q3_m = 1'b0;
    // slice 0: registered XOR of north0 and east0, clocked by west9
    img[0*48 +: 48] = mk(1, 0, 39, 63, 63, 10, 0, 16'h6666);
    // slice 1: combinational AND of north1 and south3
    img[1*48 +: 48] = mk(0, 0, 0, 63, 63, 23, 1, 16'h8888);
    // slice 2: constant one
    img[2*48 +: 48] = mk(0, 0, 0, 63, 63, 63, 63, 16'hFFFF);
    // slice 3: flip-flop fed from input 3 (east5), LUT constant zero
    img[3*48 +: 48] = mk(1, 1, 39, 15, 63, 63, 63, 16'h0000);
    // slice 4: inverse of slice 0 output via feedback code 40
    img[4*48 +: 48] = mk(0, 0, 0, 63, 63, 63, 40, 16'h5555);
    // slice 5: buffer of out-of-range code 50
    img[5*48 +: 48] = mk(0, 0, 0, 63, 63, 63, 50, 16'hAAAA);
    // slice 6: full 4-input table on north3..north0
    img[6*48 +: 48] = mk(0, 0, 0, 3, 2, 1, 0, 16'h3C5A);
    // slice 7: clock code 45 is out of range, never captures
    img[7*48 +: 48] = mk(1, 1, 45, 0, 63, 63, 63, 16'h0000);

    repeat (3) @(negedge clk_i);
    chk_bus(8'h00, "R1 outputs in reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_bus(8'h00, "R1 outputs after reset");

    for (int i = 0; i < 384; i++) begin
      @(negedge clk_i);
      cfg_en_i = 1'b1;
      cfg_bit_i = img[i];
      if (i == 200) begin
        #2 chk_bus(8'h00, "R3 quiet mid-load");
      end
    end
    @(negedge clk_i);
    cfg_en_i = 1'b0;
    #2 chk_bus(8'h00, "R3 quiet until edge samples enable low");
    @(negedge clk_i);
    #2;
    chk(slice_out_o[2], 1'b1, "R3 live after enable falls");
    chk(slice_out_o[0], 1'b0, "R1 flip-flop powers up zero");
    chk(slice_out_o[4], 1'b1, "R5 feedback of slice 0");

    for (int v = 0; v < 128; v++) begin
      logic [6:0] b;
      logic [15:0] t6;
      b = v[6:0];
      t6 = 16'h3C5A;
      bus_n_i = {6'b0, b[3:0]};
      bus_e_i = {4'b0, b[6], 4'b0, b[4]};
      bus_s_i = {6'b0, b[5], 3'b0};
      bus_w_i = '0;
      #2;
      chk(slice_out_o[1], b[1] & b[5], "R5 AND of north1 and south3");
      chk(slice_out_o[2], 1'b1, "R9 constant one");
      chk(slice_out_o[5], 1'b0, "R5 code 50 reads zero");
      chk(slice_out_o[6], t6[b[3:0]], "R4 tree order");
      chk(slice_out_o[0], q0_m, "R6 holds between clock edges");
      chk(slice_out_o[4], ~q0_m, "R8 LUT result on feedback");
      bus_w_i[9] = 1'b1;
      #2;
      q0_m = b[0] ^ b[4];
      q3_m = b[6];
      chk(slice_out_o[0], q0_m, "R6 R7 captures LUT result");
      chk(slice_out_o[3], q3_m, "R7 captures input 3");
      chk(slice_out_o[4], ~q0_m, "R8 feedback follows new state");
      chk(slice_out_o[7], 1'b0, "R6 clock code 45 never captures");
      bus_w_i[9] = 1'b0;
      #2;
      @(negedge clk_i);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule